// File: doc/BRIEF.md
# Low-Speed USB Bit-Level Receive Datapath

This block turns the D+/D- wire pair of a low-speed USB link into a stream of received bytes. The surrounding logic recovers the bit clock and detects the sync pattern. It then pulses `sync_seen` once and provides a `bit_tick` strobe at the centre of every bit cell. From that point the block samples the pair on each tick. It undoes the NRZI coding, drops the stuffed bits that the transmitter inserted, and collects the data bits into bytes. Bits arrive least significant first.

Each complete byte is presented for one cycle on `byte_data` with `byte_valid`, together with its position `wr_addr` in the receive buffer. A single-ended zero on any sample ends the packet. The block then pulses `eop_pulse` and reports how many whole bytes were stored. A byte that would go past the buffer end raises `ovf_pulse` instead. A stuffed bit that fails to toggle the line raises `stuff_err`. Both of these abort reception silently. PID and CRC checking are left to the consumer.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset all outputs are low and the block is idle. While idle, `bit_tick` samples, including SE0, produce no output pulse.
- R2: The decoded data bit is 1 when the sampled line state (D+ level, K = D+ high) equals the previous sample and 0 when it differs. The reference for the first sample after `sync_seen` is K.
- R3: Data bits are assembled least significant bit first. Each eighth data bit gives a one-cycle `byte_valid` on the cycle after its tick, with `wr_addr` counting 0, 1, 2 … from the start of the packet.
- R4: The sample that follows six consecutive decoded 1 bits is a stuffed bit and is not shifted into the byte. The trailing K-K of sync counts as the first 1 of that run.
- R5: The run of 1 bits is carried across byte boundaries.
- R6: A stuffed-bit sample equal to the previous line state gives a one-cycle `stuff_err` pulse and ends reception, with no `eop_pulse`.
- R7: A sample with D+ and D- both low ends the packet at any bit position, a stuffed-bit slot included. It gives a one-cycle `eop_pulse` with `eop_count` equal to the number of whole bytes written. A partial byte is dropped.
- R8: A byte completing when MAX_BYTES bytes are already stored is not written. It gives a one-cycle `ovf_pulse`, ends reception, and no `eop_pulse` follows.
- R9: `sync_seen` during reception restarts the packet: the byte count returns to 0 and the line reference to K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit-cell centre |
| dp | input | 1 | Sampled D+ level |
| dm | input | 1 | Sampled D- level |
| sync_seen | input | 1 | Pulse: sync pattern found, packet data follows |
| byte_valid | output | 1 | Write strobe for `byte_data` |
| byte_data | output | 8 | Received byte |
| wr_addr | output | $clog2(MAX_BYTES) | Buffer index of `byte_data` |
| eop_pulse | output | 1 | Packet ended by SE0 |
| eop_count | output | $clog2(MAX_BYTES+1) | Whole bytes received, valid with `eop_pulse` |
| ovf_pulse | output | 1 | Buffer limit exceeded, packet aborted |
| stuff_err | output | 1 | Stuffed bit did not toggle, packet aborted |

## Verification
The bench drives each packet through its own NRZI and bit-stuffing encoder, so the expected bytes are the source bytes themselves. The table of packets covers several data shapes. An all-zero byte toggles on every bit and an 0xFF byte stuffs early, since the sync's trailing one counts toward the run. A 0xF0 then 0x0F pair builds a run of eight ones that crosses the byte boundary, which separates a carried run count from one that resets per byte. The directed cases end a packet with SE0 in the middle of a byte and in a stuffed slot, corrupt one stuffed bit, overrun the buffer, and resync in mid-packet. Each of these tells the three abort paths and the restart apart.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  localparam int STUFF_RUN = 6;

  function automatic logic line_is_se0(input logic p, input logic m);
    return !p && !m;
  endfunction

  function automatic logic nrzi_decode(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl == cur_lvl;
  endfunction

  function automatic logic [7:0] lsb_insert(input logic [7:0] acc, input logic b);
    return {b, acc[7:1]};
  endfunction
endpackage

// File: rtl/usbrx_nrzi.sv
module usbrx_nrzi
  import usbrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  logic dp,
  input  logic dm,
  output logic dbit,
  output logic se0
);
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_lvl <= 1'b1;
    else if (load) prev_lvl <= 1'b1;
    else if (adv)  prev_lvl <= dp;
  end

  assign se0  = line_is_se0(dp, dm);
  assign dbit = nrzi_decode(prev_lvl, dp);
endmodule

// File: rtl/usbrx_destuff.sv
module usbrx_destuff #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  logic dbit,
  output logic stuff_slot
);
  localparam int RW = $clog2(RUN_LEN + 1);
  logic [RW-1:0] run_q;

  assign stuff_slot = (run_q == RW'(RUN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (load)       run_q <= RW'(1);
    else if (adv) begin
      if (stuff_slot)    run_q <= '0;
      else if (dbit)     run_q <= run_q + RW'(1);
      else               run_q <= '0;
    end
  end
endmodule

// File: rtl/usbrx_assembler.sv
module usbrx_assembler
  import usbrx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          dbit,
  output logic          byte_done,
  output logic [7:0]    byte_val,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [7:0] acc_q;
  logic [2:0] idx_q;

  assign byte_done = adv && (idx_q == 3'd7);
  assign byte_val  = lsb_insert(acc_q, dbit);
  assign full      = (count == CW'(MAX_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
      count <= '0;
    end else if (load) begin
      acc_q <= '0;
      idx_q <= '0;
      count <= '0;
    end else if (adv) begin
      acc_q <= byte_val;
      idx_q <= idx_q + 3'd1;
      if (byte_done && !full) count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usbrx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          dp,
  input  logic          dm,
  input  logic          sync_seen,
  output logic          byte_valid,
  output logic [7:0]    byte_data,
  output logic [AW-1:0] wr_addr,
  output logic          eop_pulse,
  output logic [CW-1:0] eop_count,
  output logic          ovf_pulse,
  output logic          stuff_err
);
  logic          active;
  logic          dbit, se0, stuff_slot;
  logic          byte_done, full;
  logic [7:0]    byte_val;
  logic [CW-1:0] count;

  // named internal events
  logic samp_ev, se0_ev, line_ev, stuff_ev, bad_stuff_ev, data_ev, ovf_ev, write_ev;

  assign samp_ev      = active && bit_tick && !sync_seen;
  assign se0_ev       = samp_ev && se0;
  assign line_ev      = samp_ev && !se0;
  assign stuff_ev     = line_ev && stuff_slot;
  assign bad_stuff_ev = stuff_ev && dbit;
  assign data_ev      = line_ev && !stuff_slot;
  assign ovf_ev       = byte_done && full;
  assign write_ev     = byte_done && !full;

  usbrx_nrzi u_nrzi (
    .clk(clk), .rst_n(rst_n), .load(sync_seen), .adv(samp_ev),
    .dp(dp), .dm(dm), .dbit(dbit), .se0(se0)
  );

  usbrx_destuff #(.RUN_LEN(STUFF_RUN)) u_destuff (
    .clk(clk), .rst_n(rst_n), .load(sync_seen), .adv(line_ev),
    .dbit(dbit), .stuff_slot(stuff_slot)
  );

  usbrx_assembler #(.MAX_BYTES(MAX_BYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .load(sync_seen), .adv(data_ev), .dbit(dbit),
    .byte_done(byte_done), .byte_val(byte_val), .full(full), .count(count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               active <= 1'b0;
    else if (sync_seen)                       active <= 1'b1;
    else if (se0_ev || bad_stuff_ev || ovf_ev) active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      wr_addr    <= '0;
      eop_pulse  <= 1'b0;
      eop_count  <= '0;
      ovf_pulse  <= 1'b0;
      stuff_err  <= 1'b0;
    end else begin
      byte_valid <= write_ev;
      eop_pulse  <= se0_ev;
      ovf_pulse  <= ovf_ev;
      stuff_err  <= bad_stuff_ev;
      if (write_ev) begin
        byte_data <= byte_val;
        wr_addr   <= AW'(count);
      end
      if (se0_ev) eop_count <= count;
    end
  end
endmodule

// File: rtl/usb_ls_rx_checker.sv
module usb_ls_rx_checker #(
  parameter int MAX_BYTES = 8,
  localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          stuff_ev,
  input logic          bad_stuff_ev,
  input logic          se0_ev,
  input logic          byte_valid,
  input logic [AW-1:0] wr_addr,
  input logic          eop_pulse,
  input logic [CW-1:0] eop_count,
  input logic          ovf_pulse,
  input logic          stuff_err
);
  a_r1_one_end_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eop_pulse, ovf_pulse, stuff_err}));

  a_r4_stuff_not_byte: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_ev |=> !byte_valid);

  a_r6_bad_stuff_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stuff_ev |=> (stuff_err && !active && !eop_pulse));

  a_r7_se0_stops: assert property (@(posedge clk) disable iff (!rst_n)
    se0_ev |=> (eop_pulse && !active && !byte_valid));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pulse |-> (eop_count <= CW'(MAX_BYTES)));

  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ({1'b0, wr_addr} < CW'(MAX_BYTES)));

  a_r8_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (!byte_valid && !active));
endmodule

bind usb_ls_rx usb_ls_rx_checker #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .stuff_ev(stuff_ev),
  .bad_stuff_ev(bad_stuff_ev), .se0_ev(se0_ev), .byte_valid(byte_valid),
  .wr_addr(wr_addr), .eop_pulse(eop_pulse), .eop_count(eop_count),
  .ovf_pulse(ovf_pulse), .stuff_err(stuff_err)
);

// File: tb/usb_ls_rx_tb_top.sv
module usb_ls_rx_tb_top;
  localparam int MAXB = 8;
  localparam int AW = $clog2(MAXB);
  localparam int CW = $clog2(MAXB + 1);

  localparam int NPKT = 4;
  localparam logic [31:0] PKT_DATA [NPKT] = '{32'h81_3C_A5_00, 32'h0F_F0_FF_7E,
                                              32'h0000_00C3, 32'h0000_125A};
  localparam int PKT_LEN [NPKT] = '{4, 4, 1, 2};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b0, dp = 1'b0, dm = 1'b1, sync_seen = 1'b0;
  logic byte_valid, eop_pulse, ovf_pulse, stuff_err;
  logic [7:0] byte_data;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] eop_count;

  always #2.5 clk = ~clk;

  usb_ls_rx #(.MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .dp(dp), .dm(dm),
    .sync_seen(sync_seen), .byte_valid(byte_valid), .byte_data(byte_data),
    .wr_addr(wr_addr), .eop_pulse(eop_pulse), .eop_count(eop_count),
    .ovf_pulse(ovf_pulse), .stuff_err(stuff_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] cap_data [32];
  int cap_addr [32];
  int ncap = 0, n_eop = 0, last_eop = -1, n_ovf = 0, n_err = 0;
  logic lvl = 1'b1;
  int run = 1;

  always @(negedge clk) begin
    if (byte_valid && ncap < 32) begin
      cap_data[ncap] = byte_data;
      cap_addr[ncap] = int'(wr_addr);
      ncap++;
    end
    if (eop_pulse) begin n_eop++; last_eop = int'(eop_count); end
    if (ovf_pulse) n_ovf++;
    if (stuff_err) n_err++;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_tick(input logic p, input logic m);
    @(negedge clk); dp = p; dm = m; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_cap();
    ncap = 0; n_eop = 0; last_eop = -1; n_ovf = 0; n_err = 0;
  endtask

  task automatic start_pkt();
    @(negedge clk); sync_seen = 1'b1;
    @(negedge clk); sync_seen = 1'b0;
    lvl = 1'b1; run = 1;
  endtask

  // NRZI + stuffing encoder; a pending stuff is emitted before the next bit
  task automatic send_bit(input logic b, input logic bad_stuff);
    if (run == 6) begin
      if (!bad_stuff) lvl = ~lvl;
      do_tick(lvl, ~lvl);
      run = 0;
    end
    if (!b) lvl = ~lvl;
    do_tick(lvl, ~lvl);
    run = b ? run + 1 : 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i], 1'b0);
  endtask

  task automatic send_se0();
    do_tick(1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!byte_valid && !eop_pulse && !ovf_pulse && !stuff_err, "R1 reset outputs",
        int'({byte_valid, eop_pulse, ovf_pulse, stuff_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    clear_cap();
    send_se0(); do_tick(1'b1, 1'b0); send_se0(); settle();
    chk(n_eop == 0 && ncap == 0, "R1 idle ignores ticks", n_eop + ncap, 0);

    // table-driven packets: R2 R3 R4 R5 R7
    for (int p = 0; p < NPKT; p++) begin
      clear_cap();
      start_pkt();
      for (int b = 0; b < PKT_LEN[p]; b++) send_byte(PKT_DATA[p][8*b +: 8]);
      send_se0(); settle();
      chk(ncap == PKT_LEN[p], "R3 byte count", ncap, PKT_LEN[p]);
      for (int b = 0; b < PKT_LEN[p] && b < ncap; b++) begin
        chk(cap_data[b] == PKT_DATA[p][8*b +: 8], "R2/R4/R5 byte value",
            int'(cap_data[b]), int'(PKT_DATA[p][8*b +: 8]));
        chk(cap_addr[b] == b, "R3 write address", cap_addr[b], b);
      end
      chk(n_eop == 1 && last_eop == PKT_LEN[p], "R7 eop count", last_eop, PKT_LEN[p]);
    end

    // R4: 0xFF needs a stuff after five data ones (sync trailing one counts)
    clear_cap(); start_pkt();
    send_byte(8'hFF); send_byte(8'hFF); send_se0(); settle();
    chk(ncap == 2 && cap_data[0] == 8'hFF && cap_data[1] == 8'hFF, "R4 stuffed 0xFF pair",
        int'(cap_data[1]), 255);

    // R5: run of ones over the boundary (0xF0 then 0x1F)
    clear_cap(); start_pkt();
    send_byte(8'hF0); send_byte(8'h1F); send_se0(); settle();
    chk(ncap == 2 && cap_data[1] == 8'h1F, "R5 run across bytes", int'(cap_data[1]), 8'h1F);

    // R6: stuffed bit that keeps the line
    clear_cap(); start_pkt();
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    send_byte(8'h00); send_se0(); settle();
    chk(n_err == 1, "R6 stuff error pulse", n_err, 1);
    chk(n_eop == 0 && ncap == 0, "R6 aborted without eop", n_eop + ncap, 0);

    // R7: SE0 mid-byte drops the partial byte
    clear_cap(); start_pkt();
    send_byte(8'h6C);
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
    send_se0(); settle();
    chk(ncap == 1 && n_eop == 1 && last_eop == 1, "R7 partial dropped", last_eop, 1);

    // R7: SE0 on a stuffed slot
    clear_cap(); start_pkt();
    send_byte(8'h00);
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
    send_se0(); settle();
    chk(n_eop == 1 && last_eop == 1 && n_err == 0, "R7 SE0 in stuff slot", last_eop, 1);

    // R8: overflow
    clear_cap(); start_pkt();
    for (int b = 0; b <= MAXB; b++) send_byte(8'(8'h11 * (b + 1)));
    send_se0(); settle();
    chk(ncap == MAXB, "R8 writes limited", ncap, MAXB);
    chk(n_ovf == 1 && n_eop == 0, "R8 overflow pulse no eop", n_ovf, 1);
    chk(cap_addr[MAXB-1] == MAXB - 1, "R8 last address", cap_addr[MAXB-1], MAXB - 1);

    // R9: resync mid-packet
    clear_cap(); start_pkt();
    send_byte(8'h55);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    settle();
    chk(ncap == 1, "R9 first byte before resync", ncap, 1);
    clear_cap(); start_pkt();
    send_byte(8'h66); send_se0(); settle();
    chk(ncap == 1 && cap_addr[0] == 0 && cap_data[0] == 8'h66, "R9 restart address",
        cap_addr[0], 0);
    chk(n_eop == 1 && last_eop == 1, "R9 restart count", last_eop, 1);

    finish_run();
  end
endmodule